// File: doc/BRIEF.md
# Multi-Block Erase Queue Timer

This block sits behind the command decoder of a block-erasable memory and turns a block-erase request into a sequenced erase run. The first selected block opens a selection window counted in clock cycles, and each further selection adds a block and restarts that window. When the window runs out, the list is closed. The queued blocks are then erased one at a time, from the lowest index upward. Each erase takes a programmable number of cycles, and a one-hot erase-enable shows which block is being erased.

The erase can be suspended. A suspend that arrives while the window is open takes effect at once. A suspend that arrives during the erase takes effect after a fixed latency, and this can happen more than once. Resume is honoured only while the external mode reports read-array. Blocks that the protection input marks as protected are skipped without an error. If every queued block is protected, the block still stays busy for a programmable time before it returns to idle. A reset request aborts the sequence while the window is open, but has no effect while the block is suspended.

Top module: `erase_queue_timer`

## Requirements
- R1: After reset, busy, suspended, etimer_act and all erase_en bits are low. A first_sel pulse in idle sets busy high and leaves etimer_act low while the selection window runs.
- R2: The window lasts WIN_CYC cycles counted from the most recent selection. Each add_sel restarts it, and etimer_act rises exactly WIN_CYC cycles after the clock edge that took the last selection.
- R3: Queued blocks are erased in ascending index order. erase_en is one-hot with bit i meaning block i, and each block is held for ERASE_CYC cycles. Selecting a block that is already queued adds no extra erase.
- R4: Once the window has expired, add_sel has no effect on which blocks are erased.
- R5: suspend_req while the window is open makes suspended high and busy low on the next edge. Selections made while suspended are ignored. A valid resume then starts the erase of the blocks already listed.
- R6: suspend_req during an erase makes suspended rise SUS_LAT cycles after the edge that took it. The erase continues from where it stopped after resume, and it can be suspended and resumed repeatedly without changing the total erase time.
- R7: resume_req has no effect unless read_mode is high.
- R8: A queued block whose prot_map bit is set is never enabled, and the other blocks are erased as usual.
- R9: If every queued block is protected, no erase_en bit rises and busy stays high for WIN_CYC+1+PROT_CYC cycles after the first selection.
- R10: abort_req while the window is open drops the list. busy falls ABORT_CYC cycles after the edge that took the request, and no block is erased.
- R11: abort_req while suspended is ignored. The block stays suspended and finishes its erase after resume.
- R12: etimer_act is high from the end of the window until the erase completes, and it is low while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_sel | input | 1 | Pulse: first block of a new erase list (index on blk_idx) |
| add_sel | input | 1 | Pulse: add the block on blk_idx to the open list |
| blk_idx | input | IDX_W | Block index for first_sel or add_sel |
| suspend_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| read_mode | input | 1 | High when the external mode is read-array |
| abort_req | input | 1 | Reset request pulse |
| prot_map | input | NUM_BLK | Protection status, one bit per block |
| erase_en | output | NUM_BLK | One-hot erase enable for the block being erased |
| busy | output | 1 | Operation in progress and not suspended |
| suspended | output | 1 | Erase suspended |
| etimer_act | output | 1 | Erase timer running (window closed, erase not finished) |

## Verification
The erase is tried with a list built from several selections that arrive out of order and include a duplicate. This shows whether the order is ascending, whether the window restarts, and whether a repeat is merged. A list that contains a protected block is compared with a list of protected blocks only, which separates skipping from the busy-only path. Suspends placed in the window are compared with suspends placed mid-erase, which separates the immediate path from the latency path. The erase is also split into three segments by two suspends, and the bench checks that the segments add up to one full erase. The resume gate and the reset request are each tried in both the window and the suspended state, which separates the cases where they act from the cases where they must be ignored.

// File: rtl/eqt_pkg.sv
package eqt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_PICK,
    ST_ERASE,
    ST_SUSP,
    ST_PROT,
    ST_ABORT
  } eqt_state_e;
endpackage

// File: rtl/eqt_downcnt.sv
module eqt_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (en && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: a drained counter stays at zero until reloaded
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> (cnt == '0));
endmodule

// File: rtl/eqt_blockmap.sv
module eqt_blockmap #(
  parameter int NB = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          drop_en,
  input  logic [IW-1:0] drop_idx,
  input  logic [NB-1:0] prot_map,
  output logic [NB-1:0] map,
  output logic          pend_any,
  output logic [IW-1:0] pend_idx
);
  logic [NB-1:0] pend;

  for (genvar g = 0; g < NB; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) map[g] <= 1'b0;
      else if (set_en && set_idx == IW'(g)) map[g] <= 1'b1;
      else if (clear || (drop_en && drop_idx == IW'(g))) map[g] <= 1'b0;
    end
  end

  assign pend     = map & ~prot_map;
  assign pend_any = |pend;

  always_comb begin
    pend_idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (pend[i]) pend_idx = IW'(i);
    end
  end

  // R3: the picked block is a queued, unprotected one
  a_r3_pick_valid: assert property (@(posedge clk) disable iff (rst)
    pend_any |-> (map[pend_idx] && !prot_map[pend_idx]));
endmodule

// File: rtl/erase_queue_timer.sv
module erase_queue_timer
  import eqt_pkg::*;
#(
  parameter int NUM_BLK   = 16,
  parameter int WIN_CYC   = 50,
  parameter int ERASE_CYC = 40,
  parameter int SUS_LAT   = 4,
  parameter int PROT_CYC  = 100,
  parameter int ABORT_CYC = 10,
  localparam int IDX_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int MAX_AB   = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC,
  localparam int MAX_CD   = (PROT_CYC > ABORT_CYC) ? PROT_CYC : ABORT_CYC,
  localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD,
  localparam int CNT_W    = $clog2(MAX_CYC + 1),
  localparam int LAT_W    = $clog2(SUS_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               first_sel,
  input  logic               add_sel,
  input  logic [IDX_W-1:0]   blk_idx,
  input  logic               suspend_req,
  input  logic               resume_req,
  input  logic               read_mode,
  input  logic               abort_req,
  input  logic [NUM_BLK-1:0] prot_map,
  output logic [NUM_BLK-1:0] erase_en,
  output logic               busy,
  output logic               suspended,
  output logic               etimer_act
);
  eqt_state_e st, nxt_st;
  logic [IDX_W-1:0] cur, nxt_cur;
  logic sus_win, nxt_sus_win;
  logic fresh, nxt_fresh;
  logic spend, nxt_spend;

  logic             ph_load, ph_en, ph_zero;
  logic [CNT_W-1:0] ph_val, ph_cnt;
  logic             lat_load, lat_en, lat_zero;
  logic [LAT_W-1:0] lat_cnt;
  logic             m_clear, m_set, m_drop, pend_any;
  logic [IDX_W-1:0] pend_idx;
  logic [NUM_BLK-1:0] map;

  eqt_downcnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
    .en(ph_en), .cnt(ph_cnt), .zero(ph_zero)
  );

  eqt_downcnt #(.W(LAT_W)) u_latency (
    .clk(clk), .rst(rst), .load(lat_load), .load_val(LAT_W'(SUS_LAT - 1)),
    .en(lat_en), .cnt(lat_cnt), .zero(lat_zero)
  );

  eqt_blockmap #(.NB(NUM_BLK), .IW(IDX_W)) u_map (
    .clk(clk), .rst(rst), .clear(m_clear), .set_en(m_set), .set_idx(blk_idx),
    .drop_en(m_drop), .drop_idx(cur), .prot_map(prot_map), .map(map),
    .pend_any(pend_any), .pend_idx(pend_idx)
  );

  always_comb begin
    nxt_st      = st;
    nxt_cur     = cur;
    nxt_sus_win = sus_win;
    nxt_fresh   = fresh;
    nxt_spend   = spend;
    ph_load     = 1'b0;
    ph_val      = '0;
    ph_en       = 1'b0;
    lat_load    = 1'b0;
    lat_en      = 1'b0;
    m_clear     = 1'b0;
    m_set       = 1'b0;
    m_drop      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        m_clear = 1'b1;
        if (first_sel) begin
          m_set     = 1'b1;
          nxt_fresh = 1'b1;
          ph_load   = 1'b1;
          ph_val    = CNT_W'(WIN_CYC - 1);
          nxt_st    = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (abort_req) begin
          m_clear = 1'b1;
          ph_load = 1'b1;
          ph_val  = CNT_W'(ABORT_CYC - 1);
          nxt_st  = ST_ABORT;
        end else if (suspend_req) begin
          nxt_sus_win = 1'b1;
          nxt_st      = ST_SUSP;
        end else if (add_sel) begin
          m_set   = 1'b1;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WIN_CYC - 1);
        end else if (ph_zero) begin
          nxt_st = ST_PICK;
        end else begin
          ph_en = 1'b1;
        end
      end
      ST_PICK: begin
        if (pend_any) begin
          nxt_cur   = pend_idx;
          nxt_fresh = 1'b0;
          ph_load   = 1'b1;
          ph_val    = CNT_W'(ERASE_CYC - 1);
          nxt_st    = ST_ERASE;
        end else if (fresh) begin
          ph_load = 1'b1;
          ph_val  = CNT_W'(PROT_CYC - 1);
          nxt_st  = ST_PROT;
        end else begin
          nxt_spend = 1'b0;
          nxt_st    = ST_IDLE;
        end
      end
      ST_ERASE: begin
        ph_en = 1'b1;
        if (ph_zero) begin
          m_drop    = 1'b1;
          nxt_spend = 1'b0;
          nxt_st    = ST_PICK;
        end else if (spend && lat_zero) begin
          nxt_spend   = 1'b0;
          nxt_sus_win = 1'b0;
          nxt_st      = ST_SUSP;
        end else if (spend) begin
          lat_en = 1'b1;
        end else if (suspend_req) begin
          nxt_spend = 1'b1;
          lat_load  = 1'b1;
        end
      end
      ST_SUSP: begin
        if (resume_req && read_mode) nxt_st = sus_win ? ST_PICK : ST_ERASE;
      end
      ST_PROT, ST_ABORT: begin
        if (ph_zero) nxt_st = ST_IDLE;
        else ph_en = 1'b1;
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= '0;
      sus_win    <= 1'b0;
      fresh      <= 1'b0;
      spend      <= 1'b0;
      erase_en   <= '0;
      busy       <= 1'b0;
      suspended  <= 1'b0;
      etimer_act <= 1'b0;
    end else begin
      st         <= nxt_st;
      cur        <= nxt_cur;
      sus_win    <= nxt_sus_win;
      fresh      <= nxt_fresh;
      spend      <= nxt_spend;
      erase_en   <= (nxt_st == ST_ERASE) ? (NUM_BLK'(1) << nxt_cur) : '0;
      busy       <= (nxt_st != ST_IDLE) && (nxt_st != ST_SUSP);
      suspended  <= (nxt_st == ST_SUSP);
      etimer_act <= (nxt_st == ST_PICK) || (nxt_st == ST_ERASE) || (nxt_st == ST_PROT);
    end
  end

  // R8: a protected block is never given an erase enable
  a_r8_skip_protected: assert property (@(posedge clk) disable iff (rst)
    (erase_en & prot_map) == '0);

  // R4: after the window, the list gains no new blocks
  a_r4_list_closed: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_WINDOW) |=> ((map & ~$past(map)) == '0));

  // R7, R11: only a gated resume leaves the suspended state
  a_r7_resume_gate: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SUSP && !(resume_req && read_mode)) |=> suspended);

  // R6: erase progress is frozen while suspended
  a_r6_progress_held: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SUSP) |=> $stable(ph_cnt));

  // R5: a suspend inside the window takes effect on the next edge
  a_r5_window_suspend: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WINDOW && suspend_req && !abort_req) |=> (suspended && !busy));

  // R12: the erase timer and enables are quiet while suspended
  a_r12_quiet_suspend: assert property (@(posedge clk) disable iff (rst)
    suspended |-> (!etimer_act && erase_en == '0));
endmodule

// File: tb/erase_queue_timer_tb_top.sv
`timescale 1ns/1ps
module erase_queue_timer_tb_top;
  localparam int NB = 8;
  localparam int IW = 3;
  localparam int W  = 12;
  localparam int E  = 40;
  localparam int L  = 4;
  localparam int P  = 30;
  localparam int A  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic first_sel = 0, add_sel = 0, suspend_req = 0, resume_req = 0;
  logic read_mode = 1, abort_req = 0;
  logic [IW-1:0] blk_idx = '0;
  logic [NB-1:0] prot_map = '0;
  logic [NB-1:0] erase_en;
  logic busy, suspended, etimer_act;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  erase_queue_timer #(
    .NUM_BLK(NB), .WIN_CYC(W), .ERASE_CYC(E), .SUS_LAT(L),
    .PROT_CYC(P), .ABORT_CYC(A)
  ) dut_i (
    .clk(clk), .rst(rst), .first_sel(first_sel), .add_sel(add_sel),
    .blk_idx(blk_idx), .suspend_req(suspend_req), .resume_req(resume_req),
    .read_mode(read_mode), .abort_req(abort_req), .prot_map(prot_map),
    .erase_en(erase_en), .busy(busy), .suspended(suspended),
    .etimer_act(etimer_act)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_first(input int idx);
    first_sel = 1; blk_idx = IW'(idx); tick(); first_sel = 0;
  endtask

  task automatic pulse_add(input int idx);
    add_sel = 1; blk_idx = IW'(idx); tick(); add_sel = 0;
  endtask

  task automatic pulse_suspend();
    suspend_req = 1; tick(); suspend_req = 0;
  endtask

  task automatic pulse_resume();
    resume_req = 1; tick(); resume_req = 0;
  endtask

  task automatic pulse_abort();
    abort_req = 1; tick(); abort_req = 0;
  endtask

  // driver side of the scoreboard: one expected erase segment
  task automatic expect_run(input int idx, input int len);
    exp_q.push_back(idx * 1000 + len);
  endtask

  task automatic ticks_until_idle(output int n);
    n = 0;
    while ((busy || suspended) && n < 2000) begin tick(); n++; end
  endtask

  task automatic ticks_until_timer(output int n);
    n = 0;
    while (!etimer_act && n < 2000) begin tick(); n++; end
  endtask

  task automatic ticks_until_erase(output int n);
    n = 0;
    while (erase_en == '0 && n < 2000) begin tick(); n++; end
  endtask

  // monitor side of the scoreboard
  logic [NB-1:0] prev_en = '0;
  int run_len = 0;
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if ($countones(erase_en) > 1) check(1'b0, "R3 one-hot", $countones(erase_en), 1);
      if (erase_en != prev_en) begin
        if (prev_en != '0) begin
          int got;
          got = 0;
          for (int i = 0; i < NB; i++) if (prev_en[i]) got = i * 1000 + run_len;
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected erase run", got, -1);
          else begin
            int want;
            want = exp_q.pop_front();
            check(got == want, "R3/R6 erase run (idx*1000+len)", got, want);
          end
        end
        run_len = (erase_en != '0) ? 1 : 0;
      end else if (erase_en != '0) begin
        run_len++;
      end
      prev_en = erase_en;
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) tick();
    rst = 0;
    tick();
    // R1 reset state
    check(!busy && !suspended && !etimer_act && erase_en == '0, "R1 reset state",
          {busy, suspended, etimer_act}, 0);

    // R1 R2 R3 R4: out-of-order list with a duplicate
    pulse_first(5);
    check(busy && !etimer_act, "R1 window open", {busy, etimer_act}, 2);
    repeat (3) tick();
    pulse_add(2);
    tick();
    pulse_add(5);
    expect_run(2, E);
    expect_run(5, E);
    ticks_until_timer(n);
    check(n == W, "R2 window restarts on last selection", n, W);
    check(erase_en == '0, "R12 timer up before first enable", erase_en, 0);
    tick();
    pulse_add(1); // R4 ignored after expiry
    ticks_until_idle(n);
    check(exp_q.size() == 0, "R4 no late block erased", exp_q.size(), 0);
    tick();

    // R8: protected block in the list is skipped
    prot_map = 8'b0000_1000;
    pulse_first(3);
    pulse_add(4);
    pulse_add(1);
    expect_run(1, E);
    expect_run(4, E);
    ticks_until_idle(n);
    check(exp_q.size() == 0, "R8 protected block skipped", exp_q.size(), 0);
    tick();

    // R9: every block protected
    pulse_first(3);
    ticks_until_idle(n);
    check(n == W + 1 + P, "R9 busy-only duration", n + 0, W + 1 + P);
    tick();
    prot_map = '0;

    // R5 R7: suspend inside the window
    pulse_first(6);
    tick();
    pulse_suspend();
    check(suspended && !busy && !etimer_act, "R5 immediate suspend",
          {suspended, busy, etimer_act}, 4);
    pulse_add(0);
    read_mode = 0;
    pulse_resume();
    tick();
    check(suspended, "R7 resume ignored outside read mode", suspended, 1);
    read_mode = 1;
    expect_run(6, E);
    pulse_resume();
    check(etimer_act && !suspended && busy, "R5 resume starts erase",
          {etimer_act, suspended, busy}, 5);
    pulse_add(7);
    ticks_until_idle(n);
    check(exp_q.size() == 0, "R5 only listed block erased", exp_q.size(), 0);
    tick();

    // R6 R11 R12: two suspensions mid-erase
    pulse_first(7);
    expect_run(7, 9);
    expect_run(7, 7);
    expect_run(7, E - 16);
    ticks_until_erase(n);
    repeat (4) tick();
    pulse_suspend();
    repeat (L - 1) tick();
    check(!suspended && erase_en != '0, "R6 suspend latency not yet", suspended, 0);
    tick();
    check(suspended && !etimer_act, "R6 R12 suspended after latency",
          {suspended, etimer_act}, 2);
    pulse_resume();
    repeat (2) tick();
    pulse_suspend();
    repeat (L) tick();
    check(suspended, "R6 second suspension", suspended, 1);
    pulse_abort();
    tick();
    check(suspended && !busy, "R11 abort ignored while suspended", suspended, 1);
    pulse_resume();
    ticks_until_idle(n);
    check(exp_q.size() == 0, "R6 segments sum to full erase", exp_q.size(), 0);
    tick();

    // R10: abort inside the window
    pulse_first(2);
    tick();
    pulse_abort();
    ticks_until_idle(n);
    check(n == A, "R10 abort duration", n, A);
    check(erase_en == '0 && !etimer_act, "R10 nothing erased", erase_en, 0);
    repeat (3) tick();

    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule